// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer

This block holds three independent 32-bit down-counters behind a small register interface. A shared run register starts or stops each channel. Each channel has a live counter, a reload constant and a control register. The count clock of a channel is the block clock divided by one of four fixed ratios. A channel that steps past zero reloads from its constant and raises a sticky underflow flag. That flag, gated by a per-channel enable, drives the channel's own interrupt line.

Software loads the constant and the counter, picks a ratio, sets the enable and then sets the run bit. It services the interrupt by writing the control register with the flag bit at 0. Writes are single-cycle strobes. Reads are combinational from the address.

Top module: `tmr_unit`

## Requirements
- R1: Run register bit i (address 0xC, bits [2:0]) lets channel i count. While bit i is 0, channel i keeps its count. Run bits above bit 2 are ignored and read 0.
- R2: Control bits [1:0] select the ratio: 0 gives /4, 1 gives /16, 2 gives /64 and 3 gives /256. The first decrement happens N clock edges after the edge that captured the run bit, and later ones follow every N edges.
- R3: Each count tick decrements the counter by one. A tick at count 0 loads the channel's constant instead of wrapping.
- R4: The reload in R3 sets the underflow flag (control bit 3). The channel interrupt output equals flag AND enable (control bit 2). Setting the enable while the flag is already set raises the interrupt.
- R5: The flag stays set until a control write carries bit 3 at 0. Such a write clears the flag and drops the interrupt on the same edge. A control write with bit 3 at 1 never sets the flag.
- R6: After reset, every counter and constant reads 0xFFFFFFFF, every control register reads 0, the run register reads 0 and all interrupts are low.
- R7: Counter (field 0) and constant (field 1) are readable and writable at any time. A counter write is visible on the next read and takes priority over a tick on the same edge.
- R8: Control bits above bit 3 are accepted on write, have no effect and read 0.
- R9: The address is split as addr[3:2] = channel (0 to 2) and addr[1:0] = field (0 counter, 1 constant, 2 control). Address 0xC is the run register. Every other address reads 0 and ignores writes.
- R10: A channel's prescaler restarts from zero when its run bit goes from 0 to 1. The first tick after a restart comes a full N edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the undivided count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 3 | Per-channel interrupt, bit i for channel i |

## Verification
A wrong divider state shows up as a counter read that changes one or more edges too early or too late. The bench samples the edge just before and the edge just after each expected tick, so such an error is caught within one prescaler period. A wrong flag or a wrong reload shows up on the irq pin and on the counter value in the cycle after the zero-count tick. A run bit that leaks between channels shows up as a stopped channel whose count has moved at the next read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int CTRL_W   = 4;      // implemented control bits
    localparam int PS_LSB   = 0;      // ratio select [1:0]
    localparam int IE_BIT   = 2;      // interrupt enable
    localparam int UF_BIT   = 3;      // underflow flag
    localparam logic [1:0] RUN_SEL = 2'd3;

    typedef enum logic [1:0] {
        FLD_COUNT = 2'd0,
        FLD_CONST = 2'd1,
        FLD_CTRL  = 2'd2,
        FLD_NONE  = 2'd3
    } field_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = DIV_W'((32'd1 << (2 * sel + 2)) - 32'd1);
        tick  = run && ((div_q & mask) == mask);
        // Held at zero while stopped, so a fresh start counts a full period.
        div_d = run ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2: ratios are at least 4, so ticks never come on back-to-back edges
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             cst_we,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cst,
    output logic [CTRL_W-1:0] ctl,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cst;
        logic [1:0]       ps;
        logic             ie;
        logic             uf;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ps = wdata[PS_LSB +: 2];
            st_d.ie = wdata[IE_BIT];
            if (!wdata[UF_BIT]) st_d.uf = 1'b0;
        end
        if (cst_we) st_d.cst = wdata;
        if (cnt_we) begin
            st_d.cnt = wdata;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.cst;
                st_d.uf  = 1'b1;   // set beats a same-edge clear
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.cst <= '1;
            st_q.ps  <= '0;
            st_q.ie  <= 1'b0;
            st_q.uf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign cst = st_q.cst;
    assign ctl = {st_q.uf, st_q.ie, st_q.ps};
    assign irq = st_q.uf & st_q.ie;

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> st_q.cnt == $past(st_q.cnt));
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && st_q.cnt == '0) |=> (st_q.cnt == $past(st_q.cst)) && st_q.uf);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.uf && !(ctl_we && !wdata[UF_BIT])) |=> st_q.uf);
    p_wr_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> st_q.cnt == $past(wdata));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NCH-1:0]    irq
);
    localparam int DIV_W = 8;   // covers the /256 ratio

    logic [1:0] sel;
    field_e     fld;
    logic       run_hit;
    logic [NCH-1:0] run_d, run_q;

    logic [CNT_W-1:0]  cnt_v [NCH];
    logic [CNT_W-1:0]  cst_v [NCH];
    logic [CTRL_W-1:0] ctl_v [NCH];

    always_comb begin
        sel     = addr[3:2];
        fld     = field_e'(addr[1:0]);
        run_hit = (sel == RUN_SEL) && (fld == FLD_COUNT);
        run_d   = run_q;
        if (wr_en && run_hit) run_d = wdata[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic tick;
        logic hit;
        assign hit = wr_en && (sel == 2'(c));

        tmr_prescale #(.DIV_W(DIV_W)) u_ps (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run_q[c]),
            .sel  (ctl_v[c][PS_LSB +: 2]),
            .tick (tick)
        );

        tmr_chan #(.CNT_W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .cnt_we(hit && fld == FLD_COUNT),
            .cst_we(hit && fld == FLD_CONST),
            .ctl_we(hit && fld == FLD_CTRL),
            .wdata (wdata),
            .cnt   (cnt_v[c]),
            .cst   (cst_v[c]),
            .ctl   (ctl_v[c]),
            .irq   (irq[c])
        );
    end

    always_comb begin
        rdata = '0;
        if (run_hit) begin
            rdata = CNT_W'(run_q);
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (sel == 2'(c)) begin
                    case (fld)
                        FLD_COUNT: rdata = cnt_v[c];
                        FLD_CONST: rdata = cst_v[c];
                        FLD_CTRL:  rdata = CNT_W'(ctl_v[c]);
                        default:   rdata = '0;
                    endcase
                end
            end
        end
    end

    // R1: a cleared run bit keeps the channel's count unless software writes it
    p_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[0] && !(wr_en && addr == 4'h0)) |=> $stable(cnt_v[0]));
    // R4: a rising interrupt needs the flag and the enable set
    p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> (ctl_v[0][UF_BIT] && ctl_v[0][IE_BIT]));
endmodule

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  wa;
        logic [31:0] wd;
        logic [3:0]  ra;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{4'h2, 32'hFFFF_FFF7, 4'h2, 32'h0000_0007},  // R8 upper bits dropped, R5 flag not set
        '{4'h5, 32'h1234_5678, 4'h5, 32'h1234_5678},  // R7 constant
        '{4'h8, 32'hDEAD_BEEF, 4'h8, 32'hDEAD_BEEF},  // R7 counter
        '{4'h6, 32'h0000_00F5, 4'h6, 32'h0000_0005},  // R8
        '{4'hF, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000},  // R9 unused
        '{4'hC, 32'hFFFF_FFF8, 4'hC, 32'h0000_0000},  // R1 upper run bits
        '{4'h3, 32'h0000_0055, 4'h3, 32'h0000_0000},  // R9 unused field
        '{4'h0, 32'h0000_0042, 4'h0, 32'h0000_0042}   // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        for (int c = 0; c < 3; c++) begin
            rd(4'(c * 4),     v); chk("R6 counter", v, 32'hFFFF_FFFF);
            rd(4'(c * 4 + 1), v); chk("R6 constant", v, 32'hFFFF_FFFF);
            rd(4'(c * 4 + 2), v); chk("R6 control", v, 32'h0);
        end
        rd(4'hC, v); chk("R6 run", v, 32'h0);
        chk("R6 irq", {29'h0, irq}, 32'h0);

        // R7 R8 R9 register table, all channels stopped
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].wa, VEC[i].wd);
            rd(VEC[i].ra, v);
            chk("R7/R8/R9 table", v, VEC[i].ex);
        end
        rd(4'h8, v); chk("R1 stopped ch2 holds", v, 32'hDEAD_BEEF);

        // R2 /4, R3 reload, R4 flag without enable
        wr(4'h0, 32'd10); wr(4'h2, 32'h0); wr(4'h1, 32'd5);
        wr(4'hC, 32'h1);
        cyc(3); rd(4'h0, v); chk("R2 /4 before tick", v, 32'd10);
        cyc(1); rd(4'h0, v); chk("R2 /4 first tick", v, 32'd9);
        rd(4'h8, v); chk("R1 ch2 still held", v, 32'hDEAD_BEEF);
        cyc(36); rd(4'h0, v); chk("R3 reach zero", v, 32'd0);
        rd(4'h2, v); chk("R4 no flag yet", v, 32'h0);
        cyc(4); rd(4'h0, v); chk("R3 reload from constant", v, 32'd5);
        rd(4'h2, v); chk("R4 flag set", v, 32'h8);
        chk("R4 irq masked", {31'h0, irq[0]}, 32'h0);
        wr(4'hC, 32'h0);
        wr(4'h2, 32'hC);   // enable with flag bit 1
        chk("R4 irq on enable", {31'h0, irq[0]}, 32'h1);
        cyc(20); rd(4'h0, v); chk("R1 stopped ch0 holds", v, 32'd5);
        wr(4'h2, 32'h4);
        chk("R5 clear drops irq", {31'h0, irq[0]}, 32'h0);
        rd(4'h2, v); chk("R5 flag cleared", v, 32'h4);
        wr(4'h2, 32'h0);

        // R4 R5 ch1 at /16 with enable
        wr(4'h4, 32'd1); wr(4'h5, 32'd7); wr(4'h6, 32'h5);
        wr(4'hC, 32'h2);
        cyc(15); rd(4'h4, v); chk("R2 /16 before tick", v, 32'd1);
        cyc(1);  rd(4'h4, v); chk("R2 /16 tick", v, 32'd0);
        chk("R4 irq low at zero", {29'h0, irq}, 32'h0);
        cyc(15); rd(4'h4, v); chk("R3 zero held until tick", v, 32'd0);
        cyc(1);  rd(4'h4, v); chk("R3 reload ch1", v, 32'd7);
        chk("R4 irq ch1 only", {29'h0, irq}, 32'h2);
        wr(4'h6, 32'hD);
        chk("R5 write of 1 keeps flag", {29'h0, irq}, 32'h2);
        wr(4'h6, 32'h5);
        chk("R5 write of 0 clears", {29'h0, irq}, 32'h0);
        wr(4'hC, 32'h0);

        // R2 /64 and /256 on ch2
        wr(4'h8, 32'd100); wr(4'hA, 32'h2);
        wr(4'hC, 32'h4);
        cyc(63); rd(4'h8, v); chk("R2 /64 before tick", v, 32'd100);
        cyc(1);  rd(4'h8, v); chk("R2 /64 tick", v, 32'd99);
        wr(4'hC, 32'h0);
        wr(4'hA, 32'h3); wr(4'h8, 32'd100);
        wr(4'hC, 32'h4);
        cyc(255); rd(4'h8, v); chk("R2 /256 before tick", v, 32'd100);
        cyc(1);   rd(4'h8, v); chk("R2 /256 tick", v, 32'd99);
        wr(4'hC, 32'h0);

        // R10 prescaler restart on ch0 at /16
        wr(4'h2, 32'h1); wr(4'h0, 32'd50);
        wr(4'hC, 32'h1);
        cyc(10);
        wr(4'hC, 32'h0);
        wr(4'hC, 32'h1);
        cyc(15); rd(4'h0, v); chk("R10 no early tick after restart", v, 32'd50);
        cyc(1);  rd(4'h0, v); chk("R10 full period after restart", v, 32'd49);

        // R7 write while running
        wr(4'h0, 32'h20);
        rd(4'h0, v); chk("R7 write while running", v, 32'h20);
        wr(4'hC, 32'h0);

        finish_run();
    end
endmodule